// File: doc/BRIEF.md
# Writeback and Branch Redirect Unit

This is the last stage of an in-order pipeline. Each cycle it may retire one instruction. From the instruction it takes the type, an operation class, the result value and the instruction's PC. From a separate in-order queue of reserved destination registers it takes the oldest entry. It then does one of three things: commits the result to the register file, redirects control flow, or retires the instruction with no effect at all.

The register file is split into a general-purpose bank and a vector bank, and each bank has its own write port. The destination index does not travel with the instruction. It is always the front entry of the reservation queue, and that entry is popped when the write happens. If a write is due while the queue is empty, a sticky error flag is raised and the write is dropped.

A jump that retires with a positive target produces four single-cycle pulses in the same cycle:
- a PC redirect;
- a full clear of the reservation queue;
- a squash that turns every younger in-flight instruction into a NOP;
- for jump-and-link only, a write of PC + 1 into general register 1.

Top module: `wb_commit_unit`

## Requirements
- R1: An instruction with op class 3 (NOP) or type 3 (invalid) retires with no register write, no pop, no redirect, no link write, no clear and no squash.
- R2: Type 0 (R) or type 1 (I) with op class 0 (plain) or 2 writes `result_i` and pops the queue. Op class 1 (store) writes nothing and pops nothing.
- R3: The write index is `q_head_i`. A write due while `q_empty_i` is high performs no write and no pop. It sets `err_o` at the next clock edge, and `err_o` then stays high until reset.
- R4: An index below NGPR (16) writes the general bank at that index. An index of NGPR or above writes the vector bank at index mod NGPR. Only one bank is written per cycle.
- R5: A type 2 (J) instruction whose result, read as signed, is greater than zero raises `redirect_o` with `redirect_pc_o` equal to the result. A result of zero or less redirects nothing.
- R6: A redirecting jump with op class 2 (jump-and-link) raises `lnk_we_o` with `lnk_data_o = pc_i + 1` (a write to general register 1). Other jumps do not raise it.
- R7: `q_clear_o` and `squash_o` are high exactly in the cycle of a redirect and low in every other cycle.
- R8: With `retire_valid_i` low, every write, pop, redirect, link, clear and squash output is low.
- R9: After reset, `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| instr_type_i | input | 2 | 0 R, 1 I, 2 J, 3 invalid |
| op_cls_i | input | 2 | 0 plain, 1 store, 2 jump-and-link, 3 NOP |
| result_i | input | XLEN | Result value or jump target |
| pc_i | input | XLEN | PC of the retiring instruction |
| q_empty_i | input | 1 | Reservation queue is empty |
| q_head_i | input | IDXW | Oldest reserved destination index |
| q_pop_o | output | 1 | Pop the queue front |
| gpr_we_o | output | 1 | General bank write enable |
| gpr_addr_o | output | GAW | General bank write index |
| vr_we_o | output | 1 | Vector bank write enable |
| vr_addr_o | output | VAW | Vector bank write index |
| wr_data_o | output | XLEN | Write data for either bank |
| redirect_o | output | 1 | PC redirect pulse |
| redirect_pc_o | output | XLEN | New PC |
| lnk_we_o | output | 1 | Write general register 1 |
| lnk_data_o | output | XLEN | Link value |
| q_clear_o | output | 1 | Empty the reservation queue |
| squash_o | output | 1 | Turn younger instructions into NOPs |
| err_o | output | 1 | Sticky empty-queue error |

## Verification
A redirect by jump-and-link is the case where several functions fall in one cycle: the redirect, the link write, the queue clear and the squash. The bench provokes it with a jump-and-link carrying a positive target and checks all four outputs in the same combinational sample. A second overlap is an empty-queue write that raises the error while the write path must stay silent. The bench judges it by observing that no write and no pop happen in that cycle, that the flag appears after the edge, and that the flag persists while a later valid write proceeds normally.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {TY_R = 2'd0, TY_I = 2'd1, TY_J = 2'd2, TY_INV = 2'd3} ityp_e;
  typedef enum logic [1:0] {OC_PLAIN = 2'd0, OC_STORE = 2'd1, OC_JAL = 2'd2, OC_NOP = 2'd3} opcls_e;
endpackage

// File: rtl/wb_classify.sv
module wb_classify
  import wb_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] type_i,
  input  logic [1:0] cls_i,
  output logic       want_write_o,
  output logic       want_jump_o,
  output logic       is_jal_o
);
  ityp_e  ty;
  opcls_e oc;
  logic   live;

  always_comb begin
    ty   = ityp_e'(type_i);
    oc   = opcls_e'(cls_i);
    live = valid_i && (oc != OC_NOP) && (ty != TY_INV);
    want_write_o = live && (ty == TY_R || ty == TY_I) && (oc != OC_STORE);
    want_jump_o  = live && (ty == TY_J);
    is_jal_o     = (oc == OC_JAL);
  end
endmodule

// File: rtl/wb_route.sv
module wb_route #(
  parameter int NGPR = 16,
  parameter int NVR  = 16,
  localparam int IDXW = $clog2(NGPR + NVR),
  localparam int GAW  = $clog2(NGPR),
  localparam int VAW  = $clog2(NVR)
) (
  input  logic            en_i,
  input  logic [IDXW-1:0] idx_i,
  output logic            gpr_we_o,
  output logic [GAW-1:0]  gpr_addr_o,
  output logic            vr_we_o,
  output logic [VAW-1:0]  vr_addr_o
);
  logic            in_vec;
  logic [IDXW-1:0] rem;

  always_comb begin
    in_vec     = (32'(idx_i) >= 32'(NGPR));
    rem        = IDXW'(32'(idx_i) % 32'(NGPR));
    gpr_we_o   = en_i && !in_vec;
    vr_we_o    = en_i && in_vec;
    gpr_addr_o = GAW'(idx_i);
    vr_addr_o  = VAW'(rem);
  end
endmodule

// File: rtl/wb_redirect.sv
module wb_redirect #(
  parameter int XLEN = 32
) (
  input  logic            want_jump_i,
  input  logic            is_jal_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            lnk_we_o,
  output logic [XLEN-1:0] lnk_data_o
);
  always_comb begin
    // only strictly positive targets take effect
    redirect_o    = want_jump_i && ($signed(target_i) > 0);
    redirect_pc_o = target_i;
    lnk_we_o      = redirect_o && is_jal_i;
    lnk_data_o    = pc_i + XLEN'(1);
  end
endmodule

// File: rtl/wb_commit_unit.sv
module wb_commit_unit #(
  parameter int XLEN = 32,
  parameter int NGPR = 16,
  parameter int NVR  = 16,
  localparam int IDXW = $clog2(NGPR + NVR),
  localparam int GAW  = $clog2(NGPR),
  localparam int VAW  = $clog2(NVR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_valid_i,
  input  logic [1:0]      instr_type_i,
  input  logic [1:0]      op_cls_i,
  input  logic [XLEN-1:0] result_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            q_empty_i,
  input  logic [IDXW-1:0] q_head_i,
  output logic            q_pop_o,
  output logic            gpr_we_o,
  output logic [GAW-1:0]  gpr_addr_o,
  output logic            vr_we_o,
  output logic [VAW-1:0]  vr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            lnk_we_o,
  output logic [XLEN-1:0] lnk_data_o,
  output logic            q_clear_o,
  output logic            squash_o,
  output logic            err_o
);
  logic want_write, want_jump, is_jal, do_write, err_q;

  wb_classify u_cls (
    .valid_i     (retire_valid_i),
    .type_i      (instr_type_i),
    .cls_i       (op_cls_i),
    .want_write_o(want_write),
    .want_jump_o (want_jump),
    .is_jal_o    (is_jal)
  );

  // no reservation to pop: drop the write
  assign do_write  = want_write && !q_empty_i;
  assign q_pop_o   = do_write;
  assign wr_data_o = result_i;

  wb_route #(.NGPR(NGPR), .NVR(NVR)) u_route (
    .en_i      (do_write),
    .idx_i     (q_head_i),
    .gpr_we_o  (gpr_we_o),
    .gpr_addr_o(gpr_addr_o),
    .vr_we_o   (vr_we_o),
    .vr_addr_o (vr_addr_o)
  );

  wb_redirect #(.XLEN(XLEN)) u_redir (
    .want_jump_i  (want_jump),
    .is_jal_i     (is_jal),
    .target_i     (result_i),
    .pc_i         (pc_i),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .lnk_we_o     (lnk_we_o),
    .lnk_data_o   (lnk_data_o)
  );

  assign q_clear_o = redirect_o;
  assign squash_o  = redirect_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          err_q <= 1'b0;
    else if (want_write && q_empty_i)     err_q <= 1'b1;
  end
  assign err_o = err_q;
endmodule

// File: rtl/wb_commit_unit_chk.sv
module wb_commit_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       retire_valid_i,
  input logic [1:0] instr_type_i,
  input logic [1:0] op_cls_i,
  input logic       q_empty_i,
  input logic       q_pop_o,
  input logic       gpr_we_o,
  input logic       vr_we_o,
  input logic       redirect_o,
  input logic       lnk_we_o,
  input logic       q_clear_o,
  input logic       squash_o,
  input logic       err_o
);
  p_nop_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && (op_cls_i == 2'd3 || instr_type_i == 2'd3)) |->
      !(gpr_we_o || vr_we_o || q_pop_o || redirect_o || lnk_we_o));

  p_pop_needs_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop_o |-> !q_empty_i);

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_one_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gpr_we_o && vr_we_o));

  p_link_needs_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_we_o |-> redirect_o);

  p_flush_with_redirect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o == (q_clear_o && squash_o));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_valid_i |-> !(gpr_we_o || vr_we_o || q_pop_o || redirect_o || squash_o));
endmodule

bind wb_commit_unit wb_commit_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .retire_valid_i(retire_valid_i),
  .instr_type_i(instr_type_i), .op_cls_i(op_cls_i), .q_empty_i(q_empty_i),
  .q_pop_o(q_pop_o), .gpr_we_o(gpr_we_o), .vr_we_o(vr_we_o),
  .redirect_o(redirect_o), .lnk_we_o(lnk_we_o), .q_clear_o(q_clear_o),
  .squash_o(squash_o), .err_o(err_o)
);

// File: tb/wb_commit_unit_tb_top.sv
module wb_commit_unit_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        retire_valid_i = 1'b0;
  logic [1:0]  instr_type_i = '0, op_cls_i = '0;
  logic [31:0] result_i = '0, pc_i = '0;
  logic        q_empty_i = 1'b1;
  logic [4:0]  q_head_i = '0;
  logic        q_pop_o, gpr_we_o, vr_we_o, redirect_o, lnk_we_o, q_clear_o, squash_o, err_o;
  logic [3:0]  gpr_addr_o, vr_addr_o;
  logic [31:0] wr_data_o, redirect_pc_o, lnk_data_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  wb_commit_unit dut_i (.*);

  // {type,cls,empty,head,result,pc, gwe,gaddr,vwe,vaddr,pop,redir,link}
  localparam logic [86:0] VEC [12] = '{
    {2'd0,2'd0,1'b0,5'd3, 32'h11,      32'h100, 1'b1,4'd3, 1'b0,4'd0, 1'b1,1'b0,1'b0},
    {2'd1,2'd0,1'b0,5'd20,32'h22,      32'h104, 1'b0,4'd0, 1'b1,4'd4, 1'b1,1'b0,1'b0},
    {2'd1,2'd1,1'b0,5'd5, 32'h33,      32'h108, 1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0,1'b0},
    {2'd0,2'd3,1'b0,5'd6, 32'h44,      32'h10c, 1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0,1'b0},
    {2'd3,2'd0,1'b0,5'd7, 32'h55,      32'h110, 1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0,1'b0},
    {2'd2,2'd0,1'b0,5'd8, 32'h40,      32'h114, 1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b1,1'b0},
    {2'd2,2'd2,1'b0,5'd9, 32'h80,      32'h10,  1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b1,1'b1},
    {2'd2,2'd2,1'b0,5'd9, 32'h0,       32'h20,  1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0,1'b0},
    {2'd2,2'd0,1'b0,5'd9, 32'hFFFFFFF0,32'h24,  1'b0,4'd0, 1'b0,4'd0, 1'b0,1'b0,1'b0},
    {2'd0,2'd0,1'b0,5'd16,32'h66,      32'h28,  1'b0,4'd0, 1'b1,4'd0, 1'b1,1'b0,1'b0},
    {2'd0,2'd2,1'b0,5'd15,32'h77,      32'h2c,  1'b1,4'd15,1'b0,4'd0, 1'b1,1'b0,1'b0},
    {2'd1,2'd0,1'b0,5'd31,32'h88,      32'h30,  1'b0,4'd0, 1'b1,4'd15,1'b1,1'b0,1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] t, input logic [1:0] c,
                       input logic e, input logic [4:0] h, input logic [31:0] r, input logic [31:0] p);
    @(negedge clk_i);
    retire_valid_i = v; instr_type_i = t; op_cls_i = c;
    q_empty_i = e; q_head_i = h; result_i = r; pc_i = p;
    #2;
  endtask

  task automatic quiet(input string tag);
    logic [6:0] act;
    act = {gpr_we_o, vr_we_o, q_pop_o, redirect_o, lnk_we_o, q_clear_o, squash_o};
    chk(act == 7'd0, tag, 64'(act), 64'd0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk(err_o == 1'b0, "R9 err after reset", 64'(err_o), 64'd0);
    quiet("R8 idle after reset");

    for (int i = 0; i < 12; i++) begin
      logic [86:0] v;
      logic        gwe, vwe, pop, rd, lk;
      logic [3:0]  ga, va;
      v = VEC[i];
      {gwe, ga, vwe, va, pop, rd, lk} = v[12:0];
      drive(1'b1, v[86:85], v[84:83], v[82], v[81:77], v[76:45], v[44:13]);
      chk(gpr_we_o == gwe, "R2/R4 gpr_we", 64'(gpr_we_o), 64'(gwe));
      if (gwe) chk(gpr_addr_o == ga, "R4 gpr_addr", 64'(gpr_addr_o), 64'(ga));
      chk(vr_we_o == vwe, "R4 vr_we", 64'(vr_we_o), 64'(vwe));
      if (vwe) chk(vr_addr_o == va, "R4 vr_addr", 64'(vr_addr_o), 64'(va));
      if (gwe || vwe) chk(wr_data_o == v[76:45], "R2 wr_data", 64'(wr_data_o), 64'(v[76:45]));
      chk(q_pop_o == pop, "R2/R3 pop", 64'(q_pop_o), 64'(pop));
      chk(redirect_o == rd, "R5 redirect", 64'(redirect_o), 64'(rd));
      if (rd) chk(redirect_pc_o == v[76:45], "R5 redirect_pc", 64'(redirect_pc_o), 64'(v[76:45]));
      chk(lnk_we_o == lk, "R6 link we", 64'(lnk_we_o), 64'(lk));
      if (lk) chk(lnk_data_o == v[44:13] + 32'd1, "R6 link data", 64'(lnk_data_o), 64'(v[44:13] + 32'd1));
      chk(q_clear_o == rd && squash_o == rd, "R7 clear/squash", 64'({q_clear_o, squash_o}), 64'({rd, rd}));
      if (v[84:83] == 2'd3 || v[86:85] == 2'd3) quiet("R1 nop/invalid silent");
    end

    // R7: pulse ends when the jump is gone
    drive(1'b0, 2'd2, 2'd2, 1'b0, 5'd0, 32'h80, 32'h0);
    quiet("R7/R8 no pulse without retire");

    // store on empty queue: no error
    drive(1'b1, 2'd1, 2'd1, 1'b1, 5'd2, 32'h5, 32'h0);
    @(negedge clk_i); #2;
    chk(err_o == 1'b0, "R2 store on empty no err", 64'(err_o), 64'd0);

    // write on empty queue
    drive(1'b1, 2'd0, 2'd0, 1'b1, 5'd4, 32'h99, 32'h0);
    chk(!gpr_we_o && !vr_we_o && !q_pop_o, "R3 empty write suppressed",
        64'({gpr_we_o, vr_we_o, q_pop_o}), 64'd0);
    chk(err_o == 1'b0, "R3 err not yet", 64'(err_o), 64'd0);
    drive(1'b1, 2'd0, 2'd0, 1'b0, 5'd4, 32'h9a, 32'h0);
    chk(err_o == 1'b1, "R3 err set", 64'(err_o), 64'd1);
    chk(gpr_we_o && gpr_addr_o == 4'd4, "R3 later write proceeds", 64'({gpr_we_o, gpr_addr_o}), 64'h14);
    drive(1'b0, 2'd0, 2'd0, 1'b0, 5'd0, 32'h0, 32'h0);
    @(negedge clk_i); #2;
    chk(err_o == 1'b1, "R3 err sticky", 64'(err_o), 64'd1);

    rst_ni = 1'b0; #2;
    chk(err_o == 1'b0, "R9 err cleared by reset", 64'(err_o), 64'd0);
    rst_ni = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule